// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies a signed multiplicand by a signed multiplier in a single combinational pass, bracketed by one result register. Each operand is first turned into its unsigned magnitude, and its sign is kept aside. The magnitudes go into an unsigned core. The core forms every single-bit partial product with its own AND term. It then folds the partial-product rows together with a linear carry-save array, where each stage absorbs one row and finalises one low product bit. A ripple-carry adder then resolves the two words that remain into the upper product bits. When exactly one operand is negative, the unsigned result is negated in two's complement before it is registered.

A caller presents both operands together with `in_valid`. On the next rising clock edge the signed product is captured, and `out_valid` goes high. While `in_valid` is low the result register keeps its last value. The default magnitude widths are 12 bits for the multiplicand and 10 bits for the multiplier. Each port carries one extra bit for the sign, which gives a 13-bit by 11-bit two's-complement multiply with a 24-bit two's-complement result.

Top module: `signed_csa_mult`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `product_o` holds the two's-complement product of `mcand_i` and `mplr_i`, with both inputs read as two's-complement numbers, truncated to 24 bits (no truncation actually occurs at default widths).
- R2: The most negative operand values (-4096 for the multiplicand, -1024 for the multiplier) give the exact product, alone or together; -4096 times -1024 yields +4194304.
- R3: When both operands are non-zero, bit 23 of `product_o` is 1 exactly when the two operand sign bits (bit 12 of `mcand_i`, bit 10 of `mplr_i`) differ.
- R4: When either operand is zero, `product_o` is all zeros, whatever the sign bits of the other operand.
- R5: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R6: While `in_valid` is low, `product_o` keeps its value even if the operands change.
- R7: While `rst_n` is low, `out_valid` is 0 and `product_o` is all zeros.
- R8: Operands of largest positive magnitude (4095 and 1023), alone or mixed with negative signs, give the exact product. These values drive the longest carry paths through the array and the final adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle; loads the result register |
| mcand_i | input | 13 | Multiplicand, two's complement |
| mplr_i | input | 11 | Multiplier, two's complement |
| out_valid | output | 1 | `product_o` was loaded at the last clock edge |
| product_o | output | 24 | Registered product, two's complement |

## Verification
The hardest inputs to reach from the ports are the most negative operands. Their magnitude is a single one above the magnitude field, so only the widened top row and top column of the array carry information. Random operands hit one of these values only once in several thousand draws. The stimulus table therefore names these values explicitly, alone, paired with each other, paired with ±1, and paired with the largest positive values. The random vectors that follow cover general carry patterns. Hold and valid timing are exercised by idling `in_valid` while the operands keep changing.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

   // Sum output of a three-input one-bit adder cell
   function automatic logic cell_sum(input logic x, input logic y, input logic z);
      return x ^ y ^ z;
   endfunction

   // Carry output of a three-input one-bit adder cell (majority)
   function automatic logic cell_carry(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

   // Number of carry-save stages needed for a multiplier of the given width
   function automatic int array_stages(input int rows);
      return rows - 1;
   endfunction

endpackage

// File: rtl/csa_operand_mag.sv
// Converts a two's-complement operand into an unsigned magnitude and a sign flag.
// The magnitude keeps the full operand width, so the most negative value
// maps to 2**(W-1) without overflow.
module csa_operand_mag #(
   parameter int W = 13
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] mag_o,
   output logic         neg_o
);
   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 2) begin : g_bad_width
         $error("csa_operand_mag: W must be at least 2");
      end
   endgenerate

   assign neg_o = val_i[W-1];
   assign mag_o = neg_o ? (~val_i + ONE) : val_i;

endmodule

// File: rtl/csa_reduce_array.sv
// Linear carry-save reduction of the N x M AND-summand matrix.
// Stage 1 is a row of N-1 half adders; every later stage is a row of N-1
// full adders. Each stage retires one low product bit. The two (N-1)-bit
// words left after the last stage go to a final carry-propagate adder.
module csa_reduce_array
   import csa_mult_pkg::*;
#(
   parameter int N = 13,   // multiplicand magnitude width (columns)
   parameter int M = 11    // multiplier magnitude width (rows)
) (
   input  logic [N-1:0] a_i,
   input  logic [M-1:0] b_i,
   output logic [M-1:0] lo_o,    // retired low product bits
   output logic [N-2:0] sum_o,   // residual sum word, weight 2**M
   output logic [N-2:0] cry_o    // residual carry word, weight 2**M
);
   localparam int STAGES = array_stages(M);

   generate
      if (N < 2) begin : g_bad_n
         $error("csa_reduce_array: N must be at least 2");
      end
      if (M < 2) begin : g_bad_m
         $error("csa_reduce_array: M must be at least 2");
      end
      if (STAGES != M - 1) begin : g_bad_stages
         $error("csa_reduce_array: stage count mismatch");
      end
   endgenerate

   // pp[j][i] = a_i[i] & b_i[j], weight 2**(i+j)
   logic [M-1:0][N-1:0] pp;
   // Per-stage cell outputs; st_u/st_c of stage j have weight 2**(j+1+k)
   logic [M-1:1][N-2:0] st_s;
   logic [M-1:1][N-2:0] st_c;
   logic [M-1:1][N-2:0] st_u;

   genvar gj, gk;
   generate
      for (gj = 0; gj < M; gj++) begin : g_row
         assign pp[gj] = a_i & {N{b_i[gj]}};
      end

      assign lo_o[0] = pp[0][0];

      for (gj = 1; gj < M; gj++) begin : g_stage
         for (gk = 0; gk < N - 1; gk++) begin : g_cell
            if (gj == 1) begin : g_half
               assign st_s[gj][gk] = pp[0][gk+1] ^ pp[1][gk];
               assign st_c[gj][gk] = pp[0][gk+1] & pp[1][gk];
            end else begin : g_full
               assign st_s[gj][gk] = cell_sum(pp[gj][gk], st_u[gj-1][gk], st_c[gj-1][gk]);
               assign st_c[gj][gk] = cell_carry(pp[gj][gk], st_u[gj-1][gk], st_c[gj-1][gk]);
            end
         end

         assign lo_o[gj] = st_s[gj][0];

         if (N > 2) begin : g_shift
            assign st_u[gj][N-3:0] = st_s[gj][N-2:1];
         end
         assign st_u[gj][N-2] = pp[gj][N-1];
      end
   endgenerate

   assign sum_o = st_u[M-1];
   assign cry_o = st_c[M-1];

endmodule

// File: rtl/csa_ripple_add.sv
// Carry-propagate adder built as a chain of one-bit cells.
module csa_ripple_add
   import csa_mult_pkg::*;
#(
   parameter int W = 12
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] s_o,
   output logic         co_o
);
   generate
      if (W < 1) begin : g_bad_width
         $error("csa_ripple_add: W must be at least 1");
      end
   endgenerate

   logic [W:0] chain;
   assign chain[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_bit
         assign s_o[gi]       = cell_sum(x_i[gi], y_i[gi], chain[gi]);
         assign chain[gi + 1] = cell_carry(x_i[gi], y_i[gi], chain[gi]);
      end
   endgenerate

   assign co_o = chain[W];

endmodule

// File: rtl/signed_csa_mult.sv
// Signed multiplier: sign/magnitude wrapper around an unsigned carry-save
// array core with a ripple final adder, result registered on in_valid.
module signed_csa_mult
   import csa_mult_pkg::*;
#(
   parameter  int MCAND_W = 12,           // multiplicand magnitude bits
   parameter  int MPLR_W  = 10,           // multiplier magnitude bits
   localparam int A_W     = MCAND_W + 1,  // multiplicand port width
   localparam int B_W     = MPLR_W + 1,   // multiplier port width
   localparam int PROD_W  = A_W + B_W     // product port width
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [A_W-1:0]    mcand_i,
   input  logic [B_W-1:0]    mplr_i,
   output logic              out_valid,
   output logic [PROD_W-1:0] product_o
);
   localparam logic [PROD_W-1:0] ONE = PROD_W'(1);

   generate
      if (MCAND_W < 1) begin : g_bad_mcand
         $error("signed_csa_mult: MCAND_W must be at least 1");
      end
      if (MPLR_W < 1) begin : g_bad_mplr
         $error("signed_csa_mult: MPLR_W must be at least 1");
      end
   endgenerate

   // ---------------- operand magnitudes ----------------
   logic [A_W-1:0] mag_a;
   logic [B_W-1:0] mag_b;
   logic           neg_a;
   logic           neg_b;

   csa_operand_mag #(.W(A_W)) u_mag_a (
      .val_i (mcand_i),
      .mag_o (mag_a),
      .neg_o (neg_a)
   );

   csa_operand_mag #(.W(B_W)) u_mag_b (
      .val_i (mplr_i),
      .mag_o (mag_b),
      .neg_o (neg_b)
   );

   // ---------------- unsigned core ----------------
   logic [B_W-1:0] lo_bits;
   logic [A_W-2:0] res_sum;
   logic [A_W-2:0] res_cry;
   logic [A_W-2:0] hi_bits;
   logic           hi_co;

   csa_reduce_array #(.N(A_W), .M(B_W)) u_array (
      .a_i   (mag_a),
      .b_i   (mag_b),
      .lo_o  (lo_bits),
      .sum_o (res_sum),
      .cry_o (res_cry)
   );

   csa_ripple_add #(.W(A_W - 1)) u_final (
      .x_i  (res_sum),
      .y_i  (res_cry),
      .s_o  (hi_bits),
      .co_o (hi_co)
   );

   logic [PROD_W-1:0] umag;
   logic [PROD_W-1:0] result_d;

   assign umag     = {hi_co, hi_bits, lo_bits};
   // Two's-complement negation of zero is zero, so no guard is needed.
   assign result_d = (neg_a ^ neg_b) ? (~umag + ONE) : umag;

   // ---------------- result register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         product_o <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            product_o <= result_d;
         end
      end
   end

   // ---------------- assertions ----------------
   logic signed [PROD_W-1:0] ref_prod;
   assign ref_prod = $signed(mcand_i) * $signed(mplr_i);

   // R1, R2, R8: registered result equals a behavioural signed product
   assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (product_o == $past(ref_prod)));

   assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (|mcand_i) && (|mplr_i)) |=>
         (product_o[PROD_W-1] == $past(mcand_i[A_W-1] ^ mplr_i[B_W-1])));

   assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((mcand_i == '0) || (mplr_i == '0))) |=> (product_o == '0));

   assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(product_o));

endmodule

// File: tb/test_signed_csa_mult.sv
`timescale 1ns/1ps
module test_signed_csa_mult;

   localparam int A_W = 13;
   localparam int B_W = 11;
   localparam int P_W = 24;
   localparam int NV  = 20;

   // Directed operand table
   localparam int TA [NV] = '{0, 0, -1, -4096, 0, 1, -1, 1, -1, 4095,
                              -4096, -4096, 4095, -4096, 1, 2730, -1365, 123, -4096, 4095};
   localparam int TB [NV] = '{0, -1, 0, 0, -1024, 1, 1, -1, -1, 1023,
                              -1024, 1023, -1024, 1, -1024, -683, 341, -45, -1, -1};

   logic           clk = 1'b0;
   logic           rst_n;
   logic           in_valid;
   logic [A_W-1:0] mcand;
   logic [B_W-1:0] mplr;
   logic           out_valid;
   logic [P_W-1:0] product;

   int errors = 0;
   int checks = 0;
   logic [P_W-1:0] last_exp;

   always #2.5 clk = ~clk;

   signed_csa_mult i_signed_csa_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mcand_i   (mcand),
      .mplr_i    (mplr),
      .out_valid (out_valid),
      .product_o (product)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input int a, input int b);
      if (a == 0 || b == 0)           return "R4";
      if (a == -4096 || b == -1024)   return "R2";
      if (a == 4095 || b == 1023)     return "R8";
      if ((a < 0) != (b < 0))         return "R3";
      return "R1";
   endfunction

   // Called at a falling edge; drives operands, checks at the next falling edge.
   task automatic mul(input int a, input int b, input string req);
      logic [P_W-1:0] exp;
      exp      = P_W'(a * b);
      mcand    = A_W'(a);
      mplr     = B_W'(b);
      in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b1, "R5", 32'(out_valid), 32'd1);
      chk(product == exp, req, 32'(product), 32'(exp));
      last_exp = exp;
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      mcand    = '0;
      mplr     = '0;
      last_exp = '0;
      repeat (3) @(negedge clk);
      // R7: reset state
      chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
      chk(product == '0, "R7", 32'(product), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R5", 32'(out_valid), 32'd0);

      // Directed table, back to back
      for (int i = 0; i < NV; i++) begin
         mul(TA[i], TB[i], tag_of(TA[i], TB[i]));
      end

      // R6 / R5: idle with changing operands
      in_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         mcand = A_W'(i * 517 + 3);
         mplr  = B_W'(-i - 7);
         @(negedge clk);
         chk(out_valid == 1'b0, "R5", 32'(out_valid), 32'd0);
         chk(product == last_exp, "R6", 32'(product), 32'(last_exp));
      end

      // R3 / R4 sign sweep on zero and unit operands
      mul(0, -1024, "R4");
      mul(-4096, 0, "R4");
      mul(-1, 1023, "R3");
      mul(-4096, -1024, "R2");

      // Random vectors, R1
      for (int i = 0; i < 3000; i++) begin
         logic signed [A_W-1:0] ra;
         logic signed [B_W-1:0] rb;
         ra = A_W'($urandom);
         rb = B_W'($urandom);
         mul(int'(ra), int'(rb), "R1");
         if (i % 97 == 0) begin
            in_valid = 1'b0;
            mcand    = ~mcand;
            @(negedge clk);
            chk(product == last_exp, "R6", 32'(product), 32'(last_exp));
         end
      end

      // R7: reset after a non-zero result
      mul(4095, 1023, "R8");
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
      chk(product == '0, "R7", 32'(product), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule